// File: doc/BRIEF.md
# AES-256 Key Expansion Step over a Vector Register Group

This block advances the AES-256 key schedule by one round key for every four-element group of a vector register. Each element is 32 bits wide, and a group holds one 128-bit round key. Two register groups feed the block. The destination group holds the older of the two previous round keys, and the result overwrites it. The source group holds the newer key. A small round immediate picks the transform. Even rounds rotate the last word, substitute it through the AES S-box and add a round constant. Odd rounds only substitute it.

The block sits in a vector datapath. The issue logic presents one operation on `req_valid` with the current `vl`, `vstart` and element-width code. One clock later the block returns the whole destination group on `dst_out` with `rsp_valid` set. Elements past `vl` are filled with ones and elements below `vstart` are left as they were. The block also returns the updated `vstart`. An operation whose length, start or element width breaks the group rules is flagged illegal and changes nothing.

Top module: `ks256_step`

## Requirements
- R1: Only bits [3:0] of `round_imm` take part; bit 4 has no effect on any output.
- R2: The working round r is `round_imm[3:0]` with bit 3 inverted when that value is below 2 or above 14, so r always lies in 2..14 (0 acts as 8, 1 as 9, 15 as 7).
- R3: When r is even, new word n0 = w0 ^ S(RotWord(w7)) ^ {rc, 24'h0}, where rc = 01 shifted left by r/2-1. RotWord moves the top byte to the bottom.
- R4: When r is odd, n0 = w0 ^ S(w7), with no rotation and no round constant.
- R5: The other new words chain: n1 = w1 ^ n0, n2 = w2 ^ n1, n3 = w3 ^ n2.
- R6: Word wk (k = 0..3) is element k of the destination group with its four bytes reversed. w7 is element 3 of the source group, byte-reversed. Result word nk is written back byte-reversed to element k.
- R7: An operation is illegal when `vl` mod 4 != 0, `vstart` mod 4 != 0, or `sew` != 3'b010 (the 32-bit code). It then raises `rsp_illegal`, returns `dst_out` equal to `dst_in`, and returns `vstart_out` equal to `vstart`.
- R8: In a legal operation with `vstart` < `vl`, every element with index >= `vl` returns all ones.
- R9: In a legal operation, every element with index < `vstart` returns its `dst_in` value.
- R10: A legal operation with `vstart` < `vl` returns `vstart_out` = 0.
- R11: A legal operation with `vstart` >= `vl` returns `dst_in` unchanged, with no tail fill, and `vstart_out` = `vstart`.
- R12: Each group uses only its own destination and source elements.
- R13: During reset `rsp_valid`, `rsp_illegal`, `dst_out` and `vstart_out` are zero.
- R14: `rsp_valid` is high for exactly the one cycle after each cycle in which `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation present this cycle |
| round_imm | input | 5 | Round immediate |
| vl | input | VL_W | Active element count |
| vstart | input | VL_W | First element to update |
| sew | input | 3 | Element width code (3'b010 = 32-bit) |
| dst_in | input | ELEMS*32 | Destination group: older key |
| src_in | input | ELEMS*32 | Source group: newer key |
| rsp_valid | output | 1 | Result present |
| rsp_illegal | output | 1 | Operation rejected |
| dst_out | output | ELEMS*32 | New destination group |
| vstart_out | output | VL_W | Updated start index |

## Verification
Three outcomes are hard to tell apart at the ports: a group skipped because it lies below `vstart`, a group filled because it lies past `vl`, and a whole operation dropped because `vstart` >= `vl`. A design that confuses them can still give the right result on full-length runs. The vector table therefore pairs different key data with partial lengths, a nonzero start, and start equal to length, including the zero-length case. The bench recomputes every element, so a wrong fill or a missing fill shows up in the specific element it affects. The remapped immediates 0, 1 and 15, and an immediate with bit 4 set, reach the round normaliser through the same table.

// File: rtl/ks256_pkg.sv
package ks256_pkg;
   localparam int EGS     = 4;
   localparam int WORD_W  = 32;
   localparam int GROUP_W = EGS * WORD_W;
   localparam logic [2:0] SEW_32 = 3'b010;

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p;
      logic [7:0] x;
      p = 8'h00;
      x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      end
      return p;
   endfunction

   // multiplicative inverse as x^254, then the affine map
   function automatic logic [7:0] sub_byte(input logic [7:0] x);
      logic [7:0] sq;
      logic [7:0] inv;
      sq  = x;
      inv = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq  = gf_mul(sq, sq);
         inv = gf_mul(inv, sq);
      end
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
             {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [7:0] rcon_byte(input logic [3:0] idx);
      if (idx < 4'd8) return 8'h01 << idx;
      else if (idx == 4'd8) return 8'h1b;
      else return 8'h36;
   endfunction

   function automatic logic [31:0] bswap32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction
endpackage

// File: rtl/ks256_round_norm.sv
module ks256_round_norm (
   input  logic [4:0] imm_i,
   output logic [3:0] round_o
);
   logic [3:0] raw;
   assign raw     = imm_i[3:0];
   assign round_o = ((raw < 4'd2) || (raw > 4'd14)) ? (raw ^ 4'b1000) : raw;

   logic unused_imm_hi;
   assign unused_imm_hi = imm_i[4];
endmodule

// File: rtl/ks256_group_xf.sv
module ks256_group_xf
   import ks256_pkg::*;
(
   input  logic [GROUP_W-1:0] older_i,
   input  logic [WORD_W-1:0]  newest_elem_i,
   input  logic [3:0]         round_i,
   output logic [GROUP_W-1:0] key_o
);
   logic [WORD_W-1:0] w_old [EGS];
   logic [WORD_W-1:0] n_wd  [EGS];
   logic [WORD_W-1:0] w7, rot, sub, tword;
   logic [2:0]        rc_idx;
   logic              even_rnd;

   assign even_rnd = ~round_i[0];
   assign w7       = bswap32(newest_elem_i);
   assign rot      = even_rnd ? {w7[23:0], w7[31:24]} : w7;
   assign rc_idx   = round_i[3:1] - 3'd1;

   for (genvar b = 0; b < 4; b++) begin : g_sbox
      assign sub[8*b +: 8] = sub_byte(rot[8*b +: 8]);
   end

   assign tword = sub ^ (even_rnd ? {rcon_byte({1'b0, rc_idx}), 24'h0} : 32'h0);

   for (genvar k = 0; k < EGS; k++) begin : g_word
      assign w_old[k] = bswap32(older_i[WORD_W*k +: WORD_W]);
      if (k == 0) begin : g_head
         assign n_wd[k] = w_old[k] ^ tword;
      end else begin : g_chain
         assign n_wd[k] = w_old[k] ^ n_wd[k-1];
      end
      assign key_o[WORD_W*k +: WORD_W] = bswap32(n_wd[k]);
   end
endmodule

// File: rtl/ks256_step.sv
module ks256_step
   import ks256_pkg::*;
#(
   parameter int ELEMS = 8,
   parameter int VL_W  = $clog2(ELEMS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [4:0]              round_imm,
   input  logic [VL_W-1:0]         vl,
   input  logic [VL_W-1:0]         vstart,
   input  logic [2:0]              sew,
   input  logic [ELEMS*WORD_W-1:0] dst_in,
   input  logic [ELEMS*WORD_W-1:0] src_in,
   output logic                    rsp_valid,
   output logic                    rsp_illegal,
   output logic [ELEMS*WORD_W-1:0] dst_out,
   output logic [VL_W-1:0]         vstart_out
);
   localparam int GROUPS = ELEMS / EGS;
   localparam int DATA_W = ELEMS * WORD_W;

   if ((ELEMS % EGS) != 0 || ELEMS < EGS) begin : g_bad_elems
      $error("ks256_step: ELEMS must be a nonzero multiple of the group size");
   end
   if ((1 << VL_W) <= ELEMS) begin : g_bad_vlw
      $error("ks256_step: VL_W too narrow for ELEMS");
   end

   logic [3:0]        round;
   logic              legal, active;
   logic [DATA_W-1:0] xf, nxt;

   ks256_round_norm u_norm (.imm_i(round_imm), .round_o(round));

   assign legal  = (vl[1:0] == 2'b00) && (vstart[1:0] == 2'b00) && (sew == SEW_32);
   assign active = legal && (vstart < vl);

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic body;
      assign body = (VL_W'(g*EGS) >= vstart) && (VL_W'(g*EGS + EGS) <= vl);

      ks256_group_xf u_xf (
         .older_i       (dst_in[g*GROUP_W +: GROUP_W]),
         .newest_elem_i (src_in[g*GROUP_W + 3*WORD_W +: WORD_W]),
         .round_i       (round),
         .key_o         (xf[g*GROUP_W +: GROUP_W])
      );

      for (genvar e = 0; e < EGS; e++) begin : g_el
         localparam int IDX = g*EGS + e;
         always_comb begin
            if (!active)
               nxt[IDX*WORD_W +: WORD_W] = dst_in[IDX*WORD_W +: WORD_W];
            else if (VL_W'(IDX) >= vl)
               nxt[IDX*WORD_W +: WORD_W] = '1;
            else if (body)
               nxt[IDX*WORD_W +: WORD_W] = xf[IDX*WORD_W +: WORD_W];
            else
               nxt[IDX*WORD_W +: WORD_W] = dst_in[IDX*WORD_W +: WORD_W];
         end
      end
   end

   // only the last source word of each group feeds the transform
   logic unused_src_words;
   assign unused_src_words = ^src_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_illegal <= 1'b0;
         dst_out     <= '0;
         vstart_out  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_illegal <= ~legal;
            dst_out     <= nxt;
            vstart_out  <= active ? '0 : vstart;
         end else begin
            rsp_illegal <= 1'b0;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r14_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r14_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r2_round_range: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (round >= 4'd2 && round <= 4'd14));
   a_r7_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_illegal |-> (rsp_valid && dst_out == $past(dst_in) && vstart_out == $past(vstart)));
   a_r10_vstart_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_illegal && ($past(vstart) < $past(vl))) |-> vstart_out == '0);
   a_r11_empty_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_illegal && ($past(vstart) >= $past(vl))) |-> dst_out == $past(dst_in));

   for (genvar e = 0; e < ELEMS; e++) begin : g_el_chk
      a_r8_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !rsp_illegal && ($past(vstart) < $past(vl)) && (VL_W'(e) >= $past(vl)))
         |-> dst_out[e*WORD_W +: WORD_W] == '1);
      a_r9_prestart_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !rsp_illegal && (VL_W'(e) < $past(vstart)))
         |-> dst_out[e*WORD_W +: WORD_W] == $past(dst_in[e*WORD_W +: WORD_W]));
   end
endmodule

// File: tb/ks256_step_tb.sv
`timescale 1ns/1ps
module ks256_step_tb;
   localparam int ELEMS = 8;
   localparam int VL_W  = 4;
   localparam int DW    = ELEMS * 32;
   localparam int NVEC  = 14;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [4:0]      round_imm = '0;
   logic [VL_W-1:0] vl = '0, vstart = '0;
   logic [2:0]      sew = 3'b010;
   logic [DW-1:0]   dst_in = '0, src_in = '0;
   logic            rsp_valid, rsp_illegal;
   logic [DW-1:0]   dst_out;
   logic [VL_W-1:0] vstart_out;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ks256_step #(.ELEMS(ELEMS), .VL_W(VL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .round_imm(round_imm),
      .vl(vl), .vstart(vstart), .sew(sew), .dst_in(dst_in), .src_in(src_in),
      .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .dst_out(dst_out),
      .vstart_out(vstart_out));

   // {imm[4:0], vl[3:0], vstart[3:0], sew[2:0], seed[7:0]}
   localparam logic [23:0] VEC [NVEC] = '{
      {5'd2,  4'd8, 4'd0, 3'd2, 8'h11},  // 0  R3 R5 R6 R12 even, first constant
      {5'd3,  4'd8, 4'd0, 3'd2, 8'h22},  // 1  R4 odd
      {5'd14, 4'd8, 4'd0, 3'd2, 8'h33},  // 2  R3 last reachable constant
      {5'd0,  4'd8, 4'd0, 3'd2, 8'h44},  // 3  R2 0 -> 8
      {5'd1,  4'd8, 4'd0, 3'd2, 8'h55},  // 4  R2 1 -> 9
      {5'd15, 4'd8, 4'd0, 3'd2, 8'h66},  // 5  R2 15 -> 7
      {5'd18, 4'd8, 4'd0, 3'd2, 8'h11},  // 6  R1 bit 4 set, same as vec 0
      {5'd6,  4'd4, 4'd0, 3'd2, 8'h77},  // 7  R8 tail group
      {5'd7,  4'd8, 4'd4, 3'd2, 8'h88},  // 8  R9 prestart group
      {5'd4,  4'd6, 4'd0, 3'd2, 8'h99},  // 9  R7 bad vl
      {5'd4,  4'd8, 4'd2, 3'd2, 8'haa},  // 10 R7 bad vstart
      {5'd4,  4'd8, 4'd0, 3'd3, 8'hbb},  // 11 R7 bad width
      {5'd4,  4'd4, 4'd4, 3'd2, 8'hcc},  // 12 R11 start equals length
      {5'd9,  4'd0, 4'd0, 3'd2, 8'hdd}   // 13 R11 zero length, R10 vstart kept
   };

   function automatic string tag_of(input int i);
      case (i)
         0: return "R3/R5/R6/R12";
         1: return "R4";
         2: return "R3";
         3, 4, 5: return "R2";
         6: return "R1";
         7: return "R8";
         8: return "R9";
         9, 10, 11: return "R7";
         default: return "R11";
      endcase
   endfunction

   function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] r = 8'h00;
      logic [7:0] aa = a;
      logic [7:0] bb = b;
      while (bb != 8'h00) begin
         if (bb[0]) r ^= aa;
         aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
         bb = bb >> 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] m_sbox(input logic [7:0] x);
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      logic [7:0] c = 8'h63;
      for (int y = 1; y < 256; y++)
         if (m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
         s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
      return s;
   endfunction

   function automatic logic [31:0] m_swap(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

   function automatic logic [31:0] gen(input logic [7:0] seed, input int idx);
      return (32'(seed) * 32'h9e3779b1) ^ (32'(idx) * 32'h85ebca6b) ^ 32'(idx + 1);
   endfunction

   task automatic model(input logic [4:0] imm, input logic [3:0] lv, input logic [3:0] ls,
                        input logic [2:0] lw, input logic [DW-1:0] d, input logic [DW-1:0] s,
                        output logic [DW-1:0] e, output logic ill, output logic [3:0] vso);
      logic [3:0]  r;
      logic [31:0] w[4];
      logic [31:0] w7, t, n;
      r = imm[3:0];
      if (r < 2 || r > 14) r = r ^ 4'd8;
      ill = (lv % 4 != 0) || (ls % 4 != 0) || (lw != 3'b010);
      e   = d;
      vso = ls;
      if (!ill && ls < lv) begin
         vso = 0;
         for (int g = 0; g < ELEMS/4; g++) begin
            if (4*g >= ls && 4*g < lv) begin
               for (int k = 0; k < 4; k++) w[k] = m_swap(d[(4*g+k)*32 +: 32]);
               w7 = m_swap(s[(4*g+3)*32 +: 32]);
               if (r[0] == 1'b0) begin
                  w7 = {w7[23:0], w7[31:24]};
                  t  = {m_sbox(w7[31:24]), m_sbox(w7[23:16]), m_sbox(w7[15:8]), m_sbox(w7[7:0])};
                  t[31:24] ^= 8'h01 << (r/2 - 1);
               end else begin
                  t  = {m_sbox(w7[31:24]), m_sbox(w7[23:16]), m_sbox(w7[15:8]), m_sbox(w7[7:0])};
               end
               n = w[0] ^ t;
               e[(4*g)*32 +: 32] = m_swap(n);
               for (int k = 1; k < 4; k++) begin
                  n = w[k] ^ n;
                  e[(4*g+k)*32 +: 32] = m_swap(n);
               end
            end
         end
         for (int el = 0; el < ELEMS; el++)
            if (el >= lv) e[el*32 +: 32] = '1;
      end
   endtask

   task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] imm, input logic [3:0] lv, input logic [3:0] ls,
                        input logic [2:0] lw, input logic [DW-1:0] d, input logic [DW-1:0] s);
      @(negedge clk);
      round_imm = imm; vl = lv; vstart = ls; sew = lw; dst_in = d; src_in = s;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, s, e;
      logic          ill;
      logic [3:0]    vso;

      // R13 reset state
      repeat (3) @(negedge clk);
      check(rsp_valid == 0 && rsp_illegal == 0, "R13 flags", DW'({rsp_valid, rsp_illegal}), '0);
      check(dst_out == '0 && vstart_out == '0, "R13 data", dst_out, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 literal: zero keys, round 2 -> every word 62636363, element 63636362
      issue(5'd2, 4'd8, 4'd0, 3'd2, '0, '0);
      check(dst_out == {8{32'h63636362}}, "R3 zero-key even", dst_out, {8{32'h63636362}});
      // R14 one-cycle pulse
      check(rsp_valid == 1'b1, "R14 valid after request", DW'(rsp_valid), DW'(1));
      @(negedge clk);
      check(rsp_valid == 1'b0, "R14 pulse ends", DW'(rsp_valid), DW'(0));

      // R4 literal: zero keys, round 3 -> every element 63636363
      issue(5'd3, 4'd8, 4'd0, 3'd2, '0, '0);
      check(dst_out == {8{32'h63636363}}, "R4 zero-key odd", dst_out, {8{32'h63636363}});

      for (int i = 0; i < NVEC; i++) begin
         for (int el = 0; el < ELEMS; el++) begin
            d[el*32 +: 32] = gen(VEC[i][7:0], el);
            s[el*32 +: 32] = gen(VEC[i][7:0] ^ 8'h5a, el + 16);
         end
         model(VEC[i][23:19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:8], d, s, e, ill, vso);
         issue(VEC[i][23:19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:8], d, s);
         check(rsp_valid == 1'b1, $sformatf("%s vec %0d valid", tag_of(i), i), DW'(rsp_valid), DW'(1));
         check(rsp_illegal == ill, $sformatf("%s vec %0d illegal", tag_of(i), i), DW'(rsp_illegal), DW'(ill));
         check(dst_out == e, $sformatf("%s vec %0d data", tag_of(i), i), dst_out, e);
         check(vstart_out == vso, $sformatf("%s/R10 vec %0d vstart", tag_of(i), i), DW'(vstart_out), DW'(vso));
      end

      // R12: change only group 0 inputs; group 1 result must not move
      for (int el = 0; el < ELEMS; el++) begin
         d[el*32 +: 32] = gen(8'h31, el);
         s[el*32 +: 32] = gen(8'h32, el);
      end
      model(5'd4, 4'd8, 4'd0, 3'd2, d, s, e, ill, vso);
      d[127:0] = ~d[127:0];
      s[127:0] = ~s[127:0];
      issue(5'd4, 4'd8, 4'd0, 3'd2, d, s);
      check(dst_out[255:128] == e[255:128], "R12 group isolation", dst_out, e);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule